// File: doc/BRIEF.md
# Hot-Plug Expander Sequencer

This block lets a switch carry the PCI Express hot-plug signals of several downstream ports through one external I/O expander on an SMBus, so the switch needs far fewer pins. The hot-plug policy logic presents the wanted output levels (indicators, power controls and the like) for every port on one vector. The block keeps a shadow of that vector. Whenever the shadow differs from what was last sent, the block writes the complete output image to the expander.

The expander pulls an active-low interrupt line low when any of its inputs changes. The block synchronises that line and reads all hot-plug inputs back in a single SMBus transaction. The values read are then published to the hot-plug logic in one step, and a one-cycle pulse marks a change in the published value.

The block talks to the SMBus only through a byte-level command port: start (or repeated start), write byte, read byte and stop. Each command ends with a done strobe that reports NACK and arbitration loss. A failed transaction is closed with a stop and run again from its start. When a transaction fails too often, the block gives it up and raises a sticky error flag.

Top module: `hpx_seq`

## Requirements
- R1: While the configuration-complete input has never been high, no command is issued, whatever the hot-plug outputs or the interrupt line do.
- R2: When configuration completes, exactly one write carrying the current output image is sent, even if the outputs do not change afterwards.
- R3: A write is START (op 0), then WRITE (op 1) of {address,0}, then WRITE of the output command byte, then WRITE of every image byte with bits [7:0] first, then STOP (op 3).
- R4: `cmd_start` is a one-cycle strobe. At most one command is outstanding. `cmd_op` and `cmd_wdata` stay stable until `cmd_done`, and the next command is strobed no earlier than the cycle after `cmd_done`.
- R5: Output changes that arrive while a transaction is in flight produce exactly one further write, and that write carries the latest image.
- R6: A low level on `exp_int_n`, after two synchronising flops, starts a read: START, WRITE {address,0}, WRITE input command byte, START, WRITE {address,1}, READ (op 2) of every input byte with `cmd_rd_last` high on the final byte only, then STOP.
- R7: After the STOP of a read succeeds, `hp_in` takes all bytes read (the first byte is bits [7:0]) in one update. `hp_in_chg` is high for exactly one cycle, and only if the value differs from the previous one.
- R8: The interrupt is level-sensitive: while it stays low, another read follows each completed read.
- R9: When a write and a read are both pending at an idle point, the write goes first.
- R10: A NACK on a written byte, or an arbitration loss on any command, is followed by STOP and then a full retry of the same transaction with the same data.
- R11: After RETRY_LIMIT retries of one transaction have failed, the block drops that transaction and sets `hp_err`, which stays high until reset.
- R12: The device address and both command bytes are taken from the configuration inputs at the time each transaction is built.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_done | input | 1 | Reset-time configuration finished |
| cfg_dev_addr | input | 7 | Expander 7-bit SMBus address |
| cfg_out_cmd | input | 8 | Expander register command for the output port |
| cfg_in_cmd | input | 8 | Expander register command for the input port |
| hp_out | input | NUM_PORTS*OUT_PER_PORT | Wanted hot-plug output levels, all ports |
| exp_int_n | input | 1 | Expander interrupt, active low, asynchronous |
| hp_in | output | NUM_PORTS*IN_PER_PORT | Published hot-plug input levels |
| hp_in_chg | output | 1 | One-cycle pulse when hp_in changes |
| hp_err | output | 1 | Sticky: a transaction ran out of retries |
| cmd_start | output | 1 | Command strobe to the SMBus byte master |
| cmd_op | output | 2 | 0 start, 1 write byte, 2 read byte, 3 stop |
| cmd_wdata | output | 8 | Byte to write |
| cmd_rd_last | output | 1 | Read byte is the last one (master NACKs it) |
| cmd_done | input | 1 | Command finished (one cycle) |
| cmd_nack | input | 1 | Written byte was not acknowledged (with cmd_done) |
| cmd_arb_lost | input | 1 | Arbitration lost (with cmd_done) |
| cmd_rdata | input | 8 | Byte read (with cmd_done) |

## Verification
An output-change write and an interrupt-driven read can both be pending in the same cycle when the engine returns to idle. The bench provokes this by changing the outputs during a read while it holds the interrupt low, so both requests are pending when that read's STOP completes. The scoreboard expects the write before the next read and flags any other order. The same collision is also triggered from idle, with an output change and the interrupt falling on one edge.

// File: rtl/hpx_pkg.sv
// Package: shared command encoding for the hot-plug expander sequencer.
// Assumes the byte-level SMBus master decodes these two-bit opcodes.
package hpx_pkg;
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } hpx_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_STOP = 2'd2
    } hpx_state_e;
endpackage

// File: rtl/hpx_sync.sv
// hpx_sync: multi-flop synchroniser for an asynchronous level input.
// Assumes the input is a slow level; the reset value marks the idle level.
module hpx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hpx_shadow.sv
// hpx_shadow: holds the shadow of the hot-plug outputs and a dirty flag
// asking for a full-image write. The flag is raised when configuration
// completes and on any change afterwards. An engine 'take' clears it, but a
// change seen in the same cycle keeps it set, so no update is lost.
module hpx_shadow #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_done,
    input  logic [W-1:0] hp_out,
    input  logic         take,
    output logic [W-1:0] image,
    output logic         dirty
);
    logic [W-1:0] shadow_q;
    logic         cfg_q;
    logic         raise;

    // A write is wanted on the configuration edge or on any output change.
    assign raise = cfg_done && (!cfg_q || (hp_out != shadow_q));

    // Track the outputs and keep the dirty flag (set wins over take).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            cfg_q    <= 1'b0;
            dirty    <= 1'b0;
        end else begin
            shadow_q <= hp_out;
            cfg_q    <= cfg_done;
            if (raise)     dirty <= 1'b1;
            else if (take) dirty <= 1'b0;
        end
    end

    assign image = shadow_q;
endmodule

// File: rtl/hpx_engine.sv
// hpx_engine: steps through the byte commands of one expander transaction
// (a full-image write or a full-input read), retries it on NACK or
// arbitration loss, and reports completed reads and exhausted retries.
// Assumes the byte master answers each cmd_start with exactly one cmd_done.
module hpx_engine
    import hpx_pkg::*;
#(
    parameter int OUT_BYTES   = 2,
    parameter int IN_BYTES    = 2,
    parameter int RETRY_LIMIT = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_done,
    input  logic                  wr_pend,
    input  logic                  rd_pend,
    input  logic [OUT_BYTES*8-1:0] image,
    input  logic [6:0]            dev_addr,
    input  logic [7:0]            out_cmd,
    input  logic [7:0]            in_cmd,
    output logic                  wr_take,
    output logic                  cmd_start,
    output hpx_op_e               cmd_op,
    output logic [7:0]            cmd_wdata,
    output logic                  cmd_rd_last,
    input  logic                  cmd_done,
    input  logic                  cmd_nack,
    input  logic                  cmd_arb_lost,
    input  logic [7:0]            cmd_rdata,
    output logic                  pub_valid,
    output logic [IN_BYTES*8-1:0] pub_data,
    output logic                  give_up
);
    localparam int WR_STEPS  = 3 + OUT_BYTES;
    localparam int RD_STEPS  = 5 + IN_BYTES;
    localparam int MAX_STEPS = (WR_STEPS > RD_STEPS) ? WR_STEPS : RD_STEPS;
    localparam int SW        = $clog2(MAX_STEPS + 1);
    localparam int RW        = $clog2(RETRY_LIMIT + 2);
    localparam logic [SW-1:0] WR_LAST = SW'(WR_STEPS - 1);
    localparam logic [SW-1:0] RD_LAST = SW'(RD_STEPS - 1);
    localparam logic [RW-1:0] RETRY_MAX = RW'(RETRY_LIMIT);

    hpx_state_e            state;
    logic                  is_rd;
    logic                  issued;
    logic                  failed;
    logic [SW-1:0]         step;
    logic [RW-1:0]         retries;
    logic [OUT_BYTES*8-1:0] tx_img;
    logic [IN_BYTES*8-1:0]  rx_buf;
    logic [7:0]            img_byte;
    logic [SW-1:0]         last_step;
    logic                  step_err;
    logic                  launch_wr;
    logic                  launch_rd;

    // Pick the image byte addressed by the current write step.
    always_comb begin
        img_byte = '0;
        for (int b = 0; b < OUT_BYTES; b++) begin
            if (step == SW'(3 + b)) img_byte = tx_img[b*8 +: 8];
        end
    end

    // Decode the command presented for the current state and step.
    always_comb begin
        cmd_op      = OP_STOP;
        cmd_wdata   = '0;
        cmd_rd_last = 1'b0;
        if (state == ST_XFER) begin
            if (step == '0) begin
                cmd_op = OP_START;
            end else if (step == SW'(1)) begin
                cmd_op    = OP_WRITE;
                cmd_wdata = {dev_addr, 1'b0};
            end else if (step == SW'(2)) begin
                cmd_op    = OP_WRITE;
                cmd_wdata = is_rd ? in_cmd : out_cmd;
            end else if (!is_rd) begin
                cmd_op    = OP_WRITE;
                cmd_wdata = img_byte;
            end else if (step == SW'(3)) begin
                cmd_op = OP_START;
            end else if (step == SW'(4)) begin
                cmd_op    = OP_WRITE;
                cmd_wdata = {dev_addr, 1'b1};
            end else begin
                cmd_op      = OP_READ;
                cmd_rd_last = (step == RD_LAST);
            end
        end
    end

    assign last_step = is_rd ? RD_LAST : WR_LAST;
    assign step_err  = cmd_arb_lost || (cmd_nack && cmd_op == OP_WRITE);
    assign cmd_start = (state != ST_IDLE) && !issued;
    assign launch_wr = (state == ST_IDLE) && cfg_done && wr_pend;
    assign launch_rd = (state == ST_IDLE) && cfg_done && !wr_pend && rd_pend;
    assign wr_take   = launch_wr;
    assign pub_data  = rx_buf;

    // Transaction sequencing, retry counting and result strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            is_rd     <= 1'b0;
            issued    <= 1'b0;
            failed    <= 1'b0;
            step      <= '0;
            retries   <= '0;
            tx_img    <= '0;
            rx_buf    <= '0;
            pub_valid <= 1'b0;
            give_up   <= 1'b0;
        end else begin
            pub_valid <= 1'b0;
            give_up   <= 1'b0;
            if (cmd_start) issued <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (launch_wr) begin
                        tx_img <= image;
                        is_rd  <= 1'b0;
                        step   <= '0;
                        state  <= ST_XFER;
                    end else if (launch_rd) begin
                        is_rd  <= 1'b1;
                        step   <= '0;
                        state  <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (cmd_done) begin
                        issued <= 1'b0;
                        for (int b = 0; b < IN_BYTES; b++) begin
                            if (is_rd && step == SW'(5 + b)) rx_buf[b*8 +: 8] <= cmd_rdata;
                        end
                        if (step_err) begin
                            failed <= 1'b1;
                            state  <= ST_STOP;
                        end else if (step == last_step) begin
                            failed <= 1'b0;
                            state  <= ST_STOP;
                        end else begin
                            step <= step + SW'(1);
                        end
                    end
                end
                ST_STOP: begin
                    if (cmd_done) begin
                        issued <= 1'b0;
                        step   <= '0;
                        if (!failed) begin
                            retries   <= '0;
                            pub_valid <= is_rd;
                            state     <= ST_IDLE;
                        end else if (retries == RETRY_MAX) begin
                            retries <= '0;
                            give_up <= 1'b1;
                            state   <= ST_IDLE;
                        end else begin
                            retries <= retries + RW'(1);
                            state   <= ST_XFER;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hpx_seq.sv
// hpx_seq: top of the hot-plug expander sequencer. It ties the shadow, the
// interrupt synchroniser and the transaction engine together, and it holds
// the published inputs, the change pulse and the sticky error flag.
// Assumes cfg_done stays high once raised and that the byte master obeys
// the cmd_start/cmd_done handshake.
module hpx_seq #(
    parameter int NUM_PORTS    = 4,
    parameter int OUT_PER_PORT = 4,
    parameter int IN_PER_PORT  = 4,
    parameter int RETRY_LIMIT  = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_done,
    input  logic [6:0]                        cfg_dev_addr,
    input  logic [7:0]                        cfg_out_cmd,
    input  logic [7:0]                        cfg_in_cmd,
    input  logic [NUM_PORTS*OUT_PER_PORT-1:0] hp_out,
    input  logic                              exp_int_n,
    output logic [NUM_PORTS*IN_PER_PORT-1:0]  hp_in,
    output logic                              hp_in_chg,
    output logic                              hp_err,
    output logic                              cmd_start,
    output logic [1:0]                        cmd_op,
    output logic [7:0]                        cmd_wdata,
    output logic                              cmd_rd_last,
    input  logic                              cmd_done,
    input  logic                              cmd_nack,
    input  logic                              cmd_arb_lost,
    input  logic [7:0]                        cmd_rdata
);
    import hpx_pkg::*;

    localparam int OUT_W     = NUM_PORTS * OUT_PER_PORT;
    localparam int IN_W      = NUM_PORTS * IN_PER_PORT;
    localparam int OUT_BYTES = (OUT_W + 7) / 8;
    localparam int IN_BYTES  = (IN_W + 7) / 8;

    logic [OUT_W-1:0]        image;
    logic [OUT_BYTES*8-1:0]  image_pad;
    logic                    dirty;
    logic                    take;
    logic                    int_sync_n;
    logic                    pub_valid;
    logic [IN_BYTES*8-1:0]   pub_data;
    logic                    give_up;
    hpx_op_e                 eng_op;

    hpx_shadow #(.W(OUT_W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_done (cfg_done),
        .hp_out   (hp_out),
        .take     (take),
        .image    (image),
        .dirty    (dirty)
    );

    hpx_sync #(.STAGES(2), .RST_VAL(1'b1)) u_int_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (exp_int_n),
        .q_sync  (int_sync_n)
    );

    // Zero-extend the image to whole bytes for transmission.
    always_comb begin
        image_pad = '0;
        image_pad[OUT_W-1:0] = image;
    end

    hpx_engine #(
        .OUT_BYTES   (OUT_BYTES),
        .IN_BYTES    (IN_BYTES),
        .RETRY_LIMIT (RETRY_LIMIT)
    ) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_done     (cfg_done),
        .wr_pend      (dirty),
        .rd_pend      (!int_sync_n),
        .image        (image_pad),
        .dev_addr     (cfg_dev_addr),
        .out_cmd      (cfg_out_cmd),
        .in_cmd       (cfg_in_cmd),
        .wr_take      (take),
        .cmd_start    (cmd_start),
        .cmd_op       (eng_op),
        .cmd_wdata    (cmd_wdata),
        .cmd_rd_last  (cmd_rd_last),
        .cmd_done     (cmd_done),
        .cmd_nack     (cmd_nack),
        .cmd_arb_lost (cmd_arb_lost),
        .cmd_rdata    (cmd_rdata),
        .pub_valid    (pub_valid),
        .pub_data     (pub_data),
        .give_up      (give_up)
    );

    assign cmd_op = eng_op;

    // Publish read-back inputs atomically and keep the sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hp_in     <= '0;
            hp_in_chg <= 1'b0;
            hp_err    <= 1'b0;
        end else begin
            hp_in_chg <= 1'b0;
            if (pub_valid) begin
                hp_in     <= pub_data[IN_W-1:0];
                hp_in_chg <= (pub_data[IN_W-1:0] != hp_in);
            end
            if (give_up) hp_err <= 1'b1;
        end
    end
endmodule

// File: rtl/hpx_seq_chk.sv
// hpx_seq_chk: protocol and output assertions for hpx_seq, bound to it.
// Assumes the synchronous active-low reset of the design.
module hpx_seq_chk #(
    parameter int IN_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_done,
    input logic            cmd_start,
    input logic            cmd_done,
    input logic [1:0]      cmd_op,
    input logic [7:0]      cmd_wdata,
    input logic [IN_W-1:0] hp_in,
    input logic            hp_in_chg,
    input logic            hp_err
);
    logic cfg_seen;
    logic pend;

    // Remember whether configuration ever completed.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_seen <= 1'b0;
        else        cfg_seen <= cfg_seen | cfg_done;
    end

    // Track one outstanding command between strobe and done.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= (pend && !cmd_done) || cmd_start;
    end

    a_r1_quiet_before_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_seen && !cfg_done) |-> !cmd_start);

    a_r4_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> !pend);

    a_r4_done_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> pend);

    a_r4_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !cmd_done) |=> ($stable(cmd_op) && $stable(cmd_wdata)));

    a_r7_change_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hp_in) |-> hp_in_chg);

    a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        hp_in_chg |=> !hp_in_chg);

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        hp_err |=> hp_err);
endmodule

bind hpx_seq hpx_seq_chk #(.IN_W(NUM_PORTS * IN_PER_PORT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_done  (cfg_done),
    .cmd_start (cmd_start),
    .cmd_done  (cmd_done),
    .cmd_op    (cmd_op),
    .cmd_wdata (cmd_wdata),
    .hp_in     (hp_in),
    .hp_in_chg (hp_in_chg),
    .hp_err    (hp_err)
);

// File: tb/hpx_seq_bench.sv
// Scoreboard bench: drivers push expected transactions; the byte-master
// model assembles observed transactions and compares them in order.
module hpx_seq_bench;
    localparam int IN_BYTES = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_done = 1'b0;
    logic [6:0]  cfg_dev_addr = 7'h27;
    logic [7:0]  cfg_out_cmd = 8'h02;
    logic [7:0]  cfg_in_cmd = 8'h01;
    logic [15:0] hp_out = 16'h0000;
    logic        exp_int_n = 1'b1;
    logic [15:0] hp_in;
    logic        hp_in_chg;
    logic        hp_err;
    logic        cmd_start;
    logic [1:0]  cmd_op;
    logic [7:0]  cmd_wdata;
    logic        cmd_rd_last;
    logic        cmd_done = 1'b0;
    logic        cmd_nack = 1'b0;
    logic        cmd_arb_lost = 1'b0;
    logic [7:0]  cmd_rdata = 8'h00;

    always #4 clk = ~clk;

    hpx_seq u_hpx_seq (
        .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done),
        .cfg_dev_addr(cfg_dev_addr), .cfg_out_cmd(cfg_out_cmd), .cfg_in_cmd(cfg_in_cmd),
        .hp_out(hp_out), .exp_int_n(exp_int_n), .hp_in(hp_in), .hp_in_chg(hp_in_chg),
        .hp_err(hp_err), .cmd_start(cmd_start), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
        .cmd_rd_last(cmd_rd_last), .cmd_done(cmd_done), .cmd_nack(cmd_nack),
        .cmd_arb_lost(cmd_arb_lost), .cmd_rdata(cmd_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [47:0] exp_q[$];
    string       tag_q[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_wr(input logic [15:0] img, input string tag);
        exp_q.push_back({8'h00, cfg_dev_addr, 1'b0, cfg_out_cmd, img[7:0], img[15:8], 8'd4});
        tag_q.push_back(tag);
    endtask

    task automatic push_rd(input string tag);
        exp_q.push_back({8'h01, cfg_dev_addr, 1'b0, cfg_in_cmd, cfg_dev_addr, 1'b1, 8'h00, 8'd2});
        tag_q.push_back(tag);
    endtask

    // Byte-master model state.
    logic        busy = 0;
    int          cnt = 0;
    logic [1:0]  m_op;
    logic [7:0]  m_wd;
    logic        m_last;
    int          start_cnt = 0;
    int          tr_start = 0;
    int          tr_ok = 0;
    int          bad_attempts = 0;
    int          inj_nack = 0;
    int          inj_arb = 0;
    logic [15:0] exp_in = 16'h0000;
    bit          in_tr = 0;
    bit          tr_bad = 0;
    int          n_starts = 0;
    int          nb = 0;
    int          rd_idx = 0;
    bit          last_bad = 0;
    logic [7:0]  bytes [0:7];
    int          chg_cnt = 0;

    // Model of the byte-level SMBus master plus the transaction monitor.
    always @(posedge clk) begin
        cmd_done     <= 1'b0;
        cmd_nack     <= 1'b0;
        cmd_arb_lost <= 1'b0;
        if (cmd_start) begin
            busy <= 1; cnt <= 2; m_op <= cmd_op; m_wd <= cmd_wdata; m_last <= cmd_rd_last;
            start_cnt <= start_cnt + 1;
        end else if (busy) begin
            if (cnt != 0) cnt <= cnt - 1;
            else begin
                busy <= 0;
                cmd_done <= 1'b1;
                case (m_op)
                    2'd0: begin
                        if (!in_tr) begin
                            in_tr = 1; tr_bad = 0; n_starts = 0; nb = 0; rd_idx = 0; last_bad = 0;
                            tr_start <= tr_start + 1;
                        end
                        n_starts = n_starts + 1;
                        if (inj_arb > 0) begin inj_arb = inj_arb - 1; cmd_arb_lost <= 1'b1; tr_bad = 1; end
                    end
                    2'd1: begin
                        if (nb < 8) bytes[nb] = m_wd;
                        nb = nb + 1;
                        if (inj_nack > 0) begin inj_nack = inj_nack - 1; cmd_nack <= 1'b1; tr_bad = 1; end
                    end
                    2'd2: begin
                        cmd_rdata <= exp_in[rd_idx*8 +: 8];
                        if (m_last != (rd_idx == IN_BYTES - 1)) last_bad = 1;
                        rd_idx = rd_idx + 1;
                    end
                    default: begin
                        in_tr = 0;
                        if (tr_bad) bad_attempts <= bad_attempts + 1;
                        else begin
                            logic [47:0] rec;
                            if (n_starts == 2)
                                rec = {8'h01, bytes[0], bytes[1], bytes[2], (last_bad ? 8'hEE : 8'h00), 8'(rd_idx)};
                            else
                                rec = {8'h00, bytes[0], bytes[1], bytes[2], bytes[3], 8'(nb)};
                            tr_ok <= tr_ok + 1;
                            if (exp_q.size() == 0) chk(0, "R9 unexpected transaction", 64'(rec), 64'h0);
                            else begin
                                logic [47:0] e;
                                string t;
                                e = exp_q.pop_front();
                                t = tag_q.pop_front();
                                chk(rec == e, t, 64'(rec), 64'(e));
                            end
                        end
                    end
                endcase
            end
        end
    end

    // Count change pulses away from the active edge.
    always @(negedge clk) if (hp_in_chg) chg_cnt++;

    task automatic settle();
        wait (exp_q.size() == 0);
        repeat (40) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 64'(exp_q.size()), 64'h0);
        finish_run();
    end

    initial begin
        int base, c0, b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hp_in == 16'h0 && !hp_err && !hp_in_chg && !cmd_start, "R7 R11 reset state",
            64'({hp_in, hp_err, hp_in_chg, cmd_start}), 64'h0);

        // R1: no traffic before configuration completes.
        hp_out = 16'h1234; exp_int_n = 1'b0;
        repeat (10) @(negedge clk);
        hp_out = 16'h4321;
        repeat (20) @(negedge clk);
        chk(start_cnt == 0, "R1 idle before cfg", 64'(start_cnt), 64'h0);
        exp_int_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2: configuration completion sends the current image once.
        hp_out = 16'h5A0F; cfg_done = 1'b1;
        push_wr(16'h5A0F, "R2 initial image");
        settle();
        chk(tr_ok == 1, "R2 single initial write", 64'(tr_ok), 64'h1);

        // R3: output changes send full images, low byte first.
        hp_out = 16'h00FF; push_wr(16'h00FF, "R3 write 00FF");
        settle();
        hp_out = 16'hF0F0; push_wr(16'hF0F0, "R3 write F0F0");
        settle();

        // R5: changes during a write give exactly one more write.
        base = tr_ok;
        hp_out = 16'h1111; push_wr(16'h1111, "R5 first write");
        wait (start_cnt > 0 && busy);
        repeat (6) @(negedge clk);
        hp_out = 16'h2222;
        repeat (3) @(negedge clk);
        hp_out = 16'h3333; push_wr(16'h3333, "R5 latest image");
        settle();
        repeat (40) @(negedge clk);
        chk(tr_ok - base == 2, "R5 exactly two writes", 64'(tr_ok - base), 64'h2);

        // R6/R7: interrupt read publishes inputs with one pulse.
        exp_in = 16'hBEEF; c0 = chg_cnt; base = tr_start;
        push_rd("R6 read sequence");
        exp_int_n = 1'b0;
        wait (tr_start == base + 1);
        @(negedge clk); exp_int_n = 1'b1;
        settle();
        chk(hp_in == 16'hBEEF, "R7 published value", 64'(hp_in), 64'hBEEF);
        chk(chg_cnt - c0 == 1, "R7 one change pulse", 64'(chg_cnt - c0), 64'h1);

        // R7: reading the same value gives no pulse.
        c0 = chg_cnt; base = tr_start;
        push_rd("R7 repeat read");
        exp_int_n = 1'b0;
        wait (tr_start == base + 1);
        @(negedge clk); exp_int_n = 1'b1;
        settle();
        chk(chg_cnt == c0 && hp_in == 16'hBEEF, "R7 no pulse on same value", 64'(chg_cnt - c0), 64'h0);

        // R8: a held interrupt causes back-to-back reads.
        exp_in = 16'h0C0C; c0 = chg_cnt; base = tr_start;
        push_rd("R8 first read"); push_rd("R8 second read");
        exp_int_n = 1'b0;
        wait (tr_start == base + 2);
        @(negedge clk); exp_int_n = 1'b1;
        settle();
        chk(tr_start == base + 2, "R8 two reads", 64'(tr_start - base), 64'h2);
        chk(hp_in == 16'h0C0C && chg_cnt - c0 == 1, "R8 value and pulse",
            64'({hp_in, 16'(chg_cnt - c0)}), 64'({16'h0C0C, 16'h1}));

        // R9: write pending with interrupt still low after a read -> write first.
        exp_in = 16'h7777; base = tr_start;
        push_rd("R9 read in flight"); push_wr(16'h4242, "R9 write before read");
        exp_int_n = 1'b0;
        wait (tr_start == base + 1);
        repeat (5) @(negedge clk);
        hp_out = 16'h4242;
        wait (tr_start == base + 2);
        @(negedge clk); exp_int_n = 1'b1;
        settle();
        chk(hp_in == 16'h7777, "R9 read value", 64'(hp_in), 64'h7777);

        // R9: change and interrupt on the same edge from idle.
        exp_in = 16'h8181; base = tr_start;
        push_wr(16'h5151, "R9 same-cycle write first"); push_rd("R9 same-cycle read second");
        hp_out = 16'h5151; exp_int_n = 1'b0;
        wait (tr_start == base + 2);
        @(negedge clk); exp_int_n = 1'b1;
        settle();
        chk(hp_in == 16'h8181, "R9 same-cycle read value", 64'(hp_in), 64'h8181);

        // R10: NACK then successful retry.
        b0 = bad_attempts;
        inj_nack = 1; hp_out = 16'h9999; push_wr(16'h9999, "R10 write after nack");
        settle();
        chk(bad_attempts - b0 == 1, "R10 one failed attempt", 64'(bad_attempts - b0), 64'h1);
        chk(!hp_err, "R10 no error after retry", 64'(hp_err), 64'h0);

        // R10: arbitration loss twice on a read, then success.
        b0 = bad_attempts; exp_in = 16'h3C3C; base = tr_start;
        inj_arb = 2; push_rd("R10 read after arb loss");
        exp_int_n = 1'b0;
        wait (tr_start == base + 1);
        @(negedge clk); exp_int_n = 1'b1;
        settle();
        chk(bad_attempts - b0 == 2 && hp_in == 16'h3C3C, "R10 arb retries",
            64'({16'(bad_attempts - b0), hp_in}), 64'({16'h2, 16'h3C3C}));

        // R11: retries exhausted -> drop and sticky error.
        b0 = bad_attempts;
        inj_nack = 4; hp_out = 16'h6666;
        wait (bad_attempts - b0 == 4);
        repeat (40) @(negedge clk);
        chk(hp_err == 1'b1, "R11 error raised", 64'(hp_err), 64'h1);
        chk(bad_attempts - b0 == 4, "R11 four attempts", 64'(bad_attempts - b0), 64'h4);
        hp_out = 16'h6767; push_wr(16'h6767, "R11 later write proceeds");
        settle();
        chk(hp_err == 1'b1, "R11 error sticky", 64'(hp_err), 64'h1);

        // R12: configuration values used for new transactions.
        cfg_dev_addr = 7'h3A; cfg_out_cmd = 8'h0A; cfg_in_cmd = 8'h0B;
        hp_out = 16'hC001; push_wr(16'hC001, "R12 new address write");
        settle();
        exp_in = 16'hD00D; base = tr_start;
        push_rd("R12 new address read");
        exp_int_n = 1'b0;
        wait (tr_start == base + 1);
        @(negedge clk); exp_int_n = 1'b1;
        settle();
        chk(hp_in == 16'hD00D, "R12 read value", 64'(hp_in), 64'hD00D);

        finish_run();
    end
endmodule